// File: doc/BRIEF.md
# Configurable Serial Master with Internal Loopback

This block is a synchronous serial master that exchanges one byte per transfer. It drives a serial clock and a data-out line, and samples a data-in line. A write-only mode word sets how it works. The word selects the clock divisor, which clock edge launches outgoing bits, which edge captures incoming bits, and the bit order. It also selects optional inversion in each direction, the level the data-out line rests at between transfers, a free-running clock, an internal loopback path for self-test, and a software reset.

Software writes the mode word through a one-cycle write strobe. A one-cycle `start` pulse loads the byte on `tx_data`. `busy` stays high for the whole frame. At the end of the frame, the captured byte appears on `rx_data` and `done` pulses for one system clock. The clock divisor runs from /2 to /256. When the divisor is odd, the high phase is one system clock longer than the low phase. Loopback takes effect only when both the free-running clock and the loopback bit are set; the data-in pin is then ignored.

Top module: `spi_master_lb`

## Requirements
- R1: The divider field, bits [2:0], gives a serial clock period of 2, 3, 4, 8, 16, 64 or 256 system clocks for codes 1 to 7 respectively.
- R2: For the odd divisor /3 the serial clock is high for 2 system clocks and low for 1. For /8 it is high for 4 and low for 4.
- R3: Bit 3 picks the launch edge and bit 4 picks the capture edge (1 = rising, 0 = falling), independently. Each bit on the data-out line is stable at the capture edge where it is sampled.
- R4: Bit 5 sets the frame order for both directions: 1 sends and stores the MSB first, 0 the LSB first.
- R5: Bit 6 complements every outgoing bit. Bit 7 complements every sampled bit before it is stored.
- R6: When no transfer is active, the data-out line equals bit 8.
- R7: With bit 9 set and a nonzero divider, the serial clock toggles while idle. With bit 9 clear, the clock stays low while idle.
- R8: With bits 9 and 10 both set, the data-in path takes the internal data-out signal, and the external data-in pin has no effect.
- R9: A write with bit 11 set ends any transfer within one cycle: busy and the serial clock go low and data-out returns to its idle level. Bit 11 is never stored.
- R10: A mode write made while busy is high leaves the stored mode unchanged.
- R11: With divider code 000 the serial clock stays low and a start pulse does not raise busy.
- R12: Busy stays high until exactly 8 capture edges have been taken. The result then appears on rx_data together with a done pulse one system clock long.
- R13: After reset, busy, done, the serial clock, data-out and rx_data are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Mode write strobe |
| cfg_wdata | input | 12 | Mode word; bit 11 is software reset |
| start | input | 1 | Begin a transfer of tx_data |
| tx_data | input | 8 | Byte to transmit |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle frame-complete pulse |
| rx_data | output | 8 | Last received byte |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
A divider counter that drifts would show on `sclk` within one serial period. It would appear as a wrong high or low length, or as a clock that runs while idle when it should not. A wrong sample counter or a wrong edge choice would show at the end of the frame: `done` would fire too early or too late, fewer or more capture edges would occur than expected, or `rx_data` would hold the wrong byte. An error in the launch shifter would show on `mosi` at the very next capture edge, so the bench rebuilds the byte seen on the wire at each capture edge and compares it with the byte that should have been sent. A mode word stored when it should have been ignored would show as a wrong idle level on `mosi` right after the frame.

// File: rtl/spi_master_lb.sv
`timescale 1ns/1ps
module spi_master_lb #(
  parameter int DW = 8,
  parameter int MW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [MW-1:0] cfg_wdata,
  input  logic          start,
  input  logic [DW-1:0] tx_data,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rx_data,
  output logic          sclk,
  output logic          mosi,
  input  logic          miso
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] LASTB = CW'(DW - 1);

  function automatic logic [8:0] div_of(input logic [2:0] c);
    case (c)
      3'd1: return 9'd2;
      3'd2: return 9'd3;
      3'd3: return 9'd4;
      3'd4: return 9'd8;
      3'd5: return 9'd16;
      3'd6: return 9'd64;
      3'd7: return 9'd256;
      default: return 9'd0;
    endcase
  endfunction

  logic [MW-2:0] mode;
  logic [7:0]    cnt;
  logic [DW-1:0] tx_sh, rx_sh;
  logic [CW-1:0] rx_n, tx_n;

  wire       tx_rise = mode[3];
  wire       rx_rise = mode[4];
  wire       msb     = mode[5];
  wire       txi     = mode[6];
  wire       rxi     = mode[7];
  wire       idle    = mode[8];
  wire       free    = mode[9];
  wire       loop    = mode[10];

  wire       srst   = cfg_we && cfg_wdata[MW-1];
  wire       wr_ok  = cfg_we && !busy;
  wire [2:0] dnew   = wr_ok ? cfg_wdata[2:0] : mode[2:0];
  wire [8:0] dn     = div_of(mode[2:0]);
  wire [8:0] dn_new = div_of(dnew) - 9'd1;
  wire [7:0] last   = 8'(dn - 9'd1);
  wire [8:0] hi     = (dn + 9'd1) >> 1;
  wire [8:0] cnt_nx = {1'b0, cnt} + 9'd1;

  wire run     = (mode[2:0] != 3'd0) && (free || busy);
  wire rise_ev = run && (cnt == last);
  wire fall_ev = run && (cnt != last) && (cnt_nx == hi);
  wire tx_ev   = tx_rise ? rise_ev : fall_ev;
  wire rx_ev   = rx_rise ? rise_ev : fall_ev;
  wire go      = start && !busy && (mode[2:0] != 3'd0) && !srst;

  wire tx_bit = msb ? tx_sh[DW-1] : tx_sh[0];
  wire mosi_i = busy ? (tx_bit ^ txi) : idle;
  wire rx_in  = (free && loop) ? mosi_i : miso;
  wire rx_b   = rx_in ^ rxi;
  wire [DW-1:0] rx_nx = msb ? {rx_sh[DW-2:0], rx_b} : {rx_b, rx_sh[DW-1:1]};
  wire [DW-1:0] tx_nx = msb ? {tx_sh[DW-2:0], 1'b0} : {1'b0, tx_sh[DW-1:1]};
  wire tx_adv = tx_ev && (tx_n < LASTB) &&
                (({1'b0, rx_n} + {{CW{1'b0}}, rx_ev}) > {1'b0, tx_n});

  assign mosi = mosi_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= '0; cnt <= 8'hFF; sclk <= 1'b0;
      busy <= 1'b0; done <= 1'b0;
      tx_sh <= '0; rx_sh <= '0; rx_data <= '0;
      rx_n <= '0; tx_n <= '0;
    end else if (srst) begin
      if (wr_ok) mode <= cfg_wdata[MW-2:0];
      cnt <= dn_new[7:0]; sclk <= 1'b0;
      busy <= 1'b0; done <= 1'b0;
      rx_n <= '0; tx_n <= '0;
    end else begin
      done <= 1'b0;
      if (wr_ok) begin
        mode <= cfg_wdata[MW-2:0];
        cnt  <= dn_new[7:0];
        sclk <= 1'b0;
      end else if (run) begin
        if (cnt == last) begin
          cnt <= 8'd0; sclk <= 1'b1;
        end else begin
          cnt <= cnt_nx[7:0];
          if (cnt_nx == hi) sclk <= 1'b0;
        end
      end else begin
        cnt <= last; sclk <= 1'b0;
      end
      if (go) begin
        busy <= 1'b1; tx_sh <= tx_data;
        rx_n <= '0; tx_n <= '0;
      end else if (busy) begin
        if (rx_ev) begin
          rx_sh <= rx_nx;
          rx_n  <= rx_n + 1'b1;
          if (rx_n == LASTB) begin
            busy <= 1'b0; done <= 1'b1; rx_data <= rx_nx;
          end
        end
        if (tx_adv) begin
          tx_sh <= tx_nx;
          tx_n  <= tx_n + 1'b1;
        end
      end
    end
  end

  a_r10_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cfg_we) |=> $stable(mode));
  a_r11_div0_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[2:0] == 3'd0) |=> (!sclk && !busy));
  a_r9_swrst_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_wdata[MW-1]) |=> (!busy && !sclk && !done));
  a_r12_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r12_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
endmodule

// File: tb/test_spi_master_lb.sv
`timescale 1ns/1ps
module test_spi_master_lb;
  logic        clk = 1'b0, rst_n = 1'b0, cfg_we = 1'b0, start = 1'b0, miso = 1'b0;
  logic [11:0] cfg_wdata = '0;
  logic [7:0]  tx_data = '0;
  logic        busy, done, sclk, mosi;
  logic [7:0]  rx_data;

  spi_master_lb i_spi_master_lb (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .start(start), .tx_data(tx_data), .busy(busy),
    .done(done), .rx_data(rx_data), .sclk(sclk), .mosi(mosi), .miso(miso));

  always #2 clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic cur_rxr = 1'b1;
  logic [7:0] cap = '0;
  int ncap = 0;
  logic sclk_d = 1'b0, busy_d = 1'b0, mosi_d = 1'b0;

  // {mode, tx, miso, expected rx, expected wire byte (first bit in bit 7)}
  localparam logic [36:0] VEC [8] = '{
    {12'h031, 8'hA5, 1'b1, 8'hFF, 8'hA5},
    {12'h00A, 8'h01, 1'b0, 8'h00, 8'h80},
    {12'h073, 8'h0F, 1'b0, 8'h00, 8'hF0},
    {12'h094, 8'hC8, 1'b0, 8'hFF, 8'h13},
    {12'h631, 8'h96, 1'b0, 8'h96, 8'h96},
    {12'h655, 8'h5A, 1'b1, 8'hA5, 8'hA5},
    {12'h6FA, 8'h3E, 1'b0, 8'h3E, 8'hC1},
    {12'h037, 8'h81, 1'b1, 8'hFF, 8'h81}
  };

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
      $finish;
    end
  end

  always @(negedge clk) begin
    if (busy_d && sclk != sclk_d && sclk == cur_rxr) begin
      cap = {cap[6:0], mosi_d};
      ncap++;
    end
    sclk_d = sclk; busy_d = busy; mosi_d = mosi;
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) begin @(negedge clk); #1; end
  endtask

  task automatic wr(input logic [11:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); #1; cfg_we = 1'b0;
  endtask

  task automatic kick(input logic [7:0] d);
    cap = '0; ncap = 0;
    @(negedge clk); start = 1'b1; tx_data = d;
    @(negedge clk); #1; start = 1'b0;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (!done && n < 4000) begin @(negedge clk); #1; n++; end
  endtask

  initial begin
    int n, h, l, tr;
    logic prev, seen;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    chk(busy == 0 && done == 0 && sclk == 0 && mosi == 0 && rx_data == 0,
        "R13 reset state", {busy, done, sclk, mosi, rx_data}, 0);

    foreach (VEC[i]) begin
      wr(VEC[i][36:25]);
      cur_rxr = VEC[i][29];
      miso = VEC[i][16];
      kick(VEC[i][24:17]);
      wait_done(n);
      chk(done == 1'b1 && busy == 1'b0, "R12 done at frame end", {done, busy}, 2);
      chk(rx_data == VEC[i][15:8], "R4/R5/R8 received byte", rx_data, VEC[i][15:8]);
      tick(1);
      chk(done == 1'b0, "R12 done width", done, 0);
      chk(cap == VEC[i][7:0], "R3/R4/R5 wire byte", cap, VEC[i][7:0]);
      chk(ncap == 8, "R12 capture edge count", ncap, 8);
    end

    // R2 / R1: /3 phase lengths, then /8
    wr(12'h202);
    tick(8);
    prev = sclk;
    while (!(prev == 0 && sclk == 1)) begin prev = sclk; tick(1); end
    h = 0; while (sclk == 1) begin h++; tick(1); end
    l = 0; while (sclk == 0) begin l++; tick(1); end
    chk(h == 2 && l == 1, "R2 odd divisor phases", h * 16 + l, 33);
    wr(12'h204);
    tick(20);
    prev = sclk;
    while (!(prev == 0 && sclk == 1)) begin prev = sclk; tick(1); end
    h = 0; while (sclk == 1) begin h++; tick(1); end
    l = 0; while (sclk == 0) begin l++; tick(1); end
    chk(h == 4 && l == 4, "R1/R2 divide by 8 phases", h * 16 + l, 68);

    // R7: free-running toggles vs stopped clock while idle
    wr(12'h201);
    tr = 0; prev = sclk;
    for (int k = 0; k < 40; k++) begin tick(1); if (sclk && !prev) tr++; prev = sclk; end
    chk(tr >= 19 && tr <= 21, "R1/R7 free-running rises in 40 cycles", tr, 20);
    wr(12'h001);
    tr = 0; prev = sclk;
    for (int k = 0; k < 40; k++) begin tick(1); if (sclk != prev) tr++; prev = sclk; end
    chk(tr == 0, "R7 idle clock held low", tr, 0);

    // R11: reserved divider code
    wr(12'h200);
    kick(8'h55);
    seen = 1'b0;
    for (int k = 0; k < 40; k++) begin tick(1); if (busy || sclk) seen = 1'b1; end
    chk(seen == 1'b0, "R11 divider 000 stopped", seen, 0);

    // R10: write while busy is ignored (idle level stays 0)
    wr(12'h037);
    cur_rxr = 1'b1; miso = 1'b1;
    kick(8'hF0);
    tick(10);
    wr(12'h137);
    wait_done(n);
    tick(1);
    chk(mosi == 1'b0, "R10 ignored write, idle level", mosi, 0);

    // R6: idle level follows bit 8
    wr(12'h137);
    chk(mosi == 1'b1, "R6 idle high", mosi, 1);
    wr(12'h037);
    chk(mosi == 1'b0, "R6 idle low", mosi, 0);

    // R9: software reset aborts a transfer
    wr(12'h137);
    kick(8'h00);
    tick(30);
    chk(busy == 1'b1, "R9 transfer running before reset", busy, 1);
    wr(12'h800);
    chk(busy == 0 && sclk == 0 && mosi == 1, "R9 abort to idle", {busy, sclk, mosi}, 1);
    tick(20);
    chk(busy == 0 && done == 0, "R9 stays idle after reset", {busy, done}, 0);
    miso = 1'b0;
    kick(8'hAA);
    wait_done(n);
    chk(rx_data == 8'h00 && done == 1'b1, "R9 mode kept after reset write", rx_data, 0);

    summary();
    $finish;
  end
endmodule